// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side. The first is a global predictor: a table of 2-bit counters indexed only by the outcomes of the most recent branches. The second is a two-level local predictor. Here a per-branch history table, indexed by the branch address, supplies a pattern of that branch's own past outcomes, and the pattern indexes a table of 3-bit counters. A third table of 2-bit counters, indexed by branch address, decides for each branch which of the two predictors to believe.

A lookup is purely combinational. The front end presents a branch PC and receives, in the same cycle, the final direction, both component guesses, the chooser's selection, and the two indices that were used. The pipeline keeps these values with the branch. When the branch resolves, it returns them on the update port together with the real outcome. One update trains both components at the saved indices and adjusts the chooser when the two components disagreed. It also shifts the outcome into the global history and into that branch's local history.

Top module: `tourn_pred`

## Requirements
- R1: After reset, the global history and every local history read zero. Every 2-bit counter holds 01 and every 3-bit counter holds 011. A lookup therefore returns not-taken from both components, with lk_sel_global = 0 (local chosen).
- R2: On each cycle with up_valid = 1, the global history shifts left by one and up_taken (1 = taken) enters at bit 0. lk_gidx always shows the current global history.
- R3: The local history entry is selected by pc[11:2], so addresses that differ only in other bits share an entry. An update shifts up_taken into bit 0 of the entry for up_pc. lk_lpat shows the entry for lk_pc. Other entries do not change.
- R4: The global counter at up_gidx counts up on taken and down on not-taken, saturating at 00 and 11. lk_gpred is the MSB of the counter at lk_gidx, regardless of lk_pc. Starting from 11, one not-taken outcome still predicts taken.
- R5: The local 3-bit counter at up_lpat saturates at 000 and 111. lk_lpred is its MSB.
- R6: The chooser counter at pc[13:2] changes only when up_gpred differs from up_lpred. It counts up when the global guess matched up_taken and down otherwise, saturating at 00 and 11. lk_sel_global is its MSB (1 = use global).
- R7: lk_taken equals lk_gpred when lk_sel_global is 1 and lk_lpred when it is 0.
- R8: When a lookup and an update touch the same entries in one cycle, the lookup returns the values from before the update. The update is visible from the next cycle on.
- R9: In a cycle with up_valid = 0, no history or counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Final direction (1 = taken) |
| lk_sel_global | output | 1 | Chooser picked the global component |
| lk_gpred | output | 1 | Global component guess |
| lk_lpred | output | 1 | Local component guess |
| lk_gidx | output | GH_W | Global counter index (current global history) |
| lk_lpat | output | LH_W | Local counter index (history of this branch) |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome |
| up_gidx | input | GH_W | lk_gidx saved at lookup |
| up_lpat | input | LH_W | lk_lpat saved at lookup |
| up_gpred | input | 1 | lk_gpred saved at lookup |
| up_lpred | input | 1 | lk_lpred saved at lookup |

## Verification
The lookup and the update can both target the same branch in the same clock cycle. The bench provokes this by presenting a lookup and an update for one address together. The update is built to change the chooser, the global history and that branch's local history all at once. All lookup outputs are sampled before the clock edge and are expected to show the old state. They are sampled again one cycle later, when the new chooser selection and the shifted indices must appear.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

  // Saturating step of a counter whose largest value is top.
  function automatic logic [7:0] sat_step(input logic [7:0] v, input logic up,
                                          input logic [7:0] top);
    if (up) return (v == top) ? v : v + 8'd1;
    else    return (v == 8'd0) ? v : v - 8'd1;
  endfunction

  // Value that means "weakly not-taken" for a counter of width w.
  function automatic logic [7:0] weak_nt(input int w);
    return 8'((1 << (w - 1)) - 1);
  endfunction

endpackage

// File: rtl/sat_table.sv
module sat_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  import tourn_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [7:0] TOP = 8'((1 << CTR_W) - 1);
  localparam logic [CTR_W-1:0] INIT = CTR_W'(weak_nt(CTR_W));

  logic [CTR_W-1:0] mem [DEPTH];
  logic [7:0]       cur_w;
  logic [7:0]       nxt_w;

  assign cur_w  = 8'(mem[wr_idx]);
  assign nxt_w  = sat_step(cur_w, wr_up, TOP);
  assign rd_msb = mem[rd_idx][CTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (we) begin
      mem[wr_idx] <= nxt_w[CTR_W-1:0];
    end
  end
endmodule

// File: rtl/hist_table.sv
module hist_table #(
  parameter int IDX_W = 10,
  parameter int H_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [H_W-1:0]   rd_hist,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= {mem[wr_idx][H_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int GH_W     = 12,
  parameter int LH_W     = 10,
  parameter int LHT_IDX_W = 10,
  parameter int CH_IDX_W = 12,
  parameter int G_CTR_W  = 2,
  parameter int L_CTR_W  = 3,
  parameter int CH_CTR_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_sel_global,
  output logic            lk_gpred,
  output logic            lk_lpred,
  output logic [GH_W-1:0] lk_gidx,
  output logic [LH_W-1:0] lk_lpat,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [GH_W-1:0] up_gidx,
  input  logic [LH_W-1:0] up_lpat,
  input  logic            up_gpred,
  input  logic            up_lpred
);

  // Named internal events
  logic [GH_W-1:0]      ghist;
  logic [CH_IDX_W-1:0]  lk_ch_idx, up_ch_idx;
  logic [LHT_IDX_W-1:0] lk_lh_idx, up_lh_idx;
  logic                 ch_we;
  logic                 ch_toward_global;
  logic                 unused_pc;

  assign lk_ch_idx = lk_pc[PC_LSB +: CH_IDX_W];
  assign up_ch_idx = up_pc[PC_LSB +: CH_IDX_W];
  assign lk_lh_idx = lk_pc[PC_LSB +: LHT_IDX_W];
  assign up_lh_idx = up_pc[PC_LSB +: LHT_IDX_W];
  assign unused_pc = ^{lk_pc, up_pc};

  assign ch_we            = up_valid && (up_gpred != up_lpred);
  assign ch_toward_global = (up_gpred == up_taken);

  // Global history register
  always_ff @(posedge clk) begin
    if (!rst_n)        ghist <= '0;
    else if (up_valid) ghist <= {ghist[GH_W-2:0], up_taken};
  end
  assign lk_gidx = ghist;

  sat_table #(.IDX_W(GH_W), .CTR_W(G_CTR_W)) u_gtab (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_msb(lk_gpred),
    .we(up_valid), .wr_idx(up_gidx), .wr_up(up_taken)
  );

  hist_table #(.IDX_W(LHT_IDX_W), .H_W(LH_W)) u_lhist (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lh_idx), .rd_hist(lk_lpat),
    .we(up_valid), .wr_idx(up_lh_idx), .wr_bit(up_taken)
  );

  sat_table #(.IDX_W(LH_W), .CTR_W(L_CTR_W)) u_ltab (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lpat), .rd_msb(lk_lpred),
    .we(up_valid), .wr_idx(up_lpat), .wr_up(up_taken)
  );

  sat_table #(.IDX_W(CH_IDX_W), .CTR_W(CH_CTR_W)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_ch_idx), .rd_msb(lk_sel_global),
    .we(ch_we), .wr_idx(up_ch_idx), .wr_up(ch_toward_global)
  );

  assign lk_taken = lk_sel_global ? lk_gpred : lk_lpred;

endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
  parameter int PC_W = 32,
  parameter int GH_W = 12,
  parameter int LH_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic [PC_W-1:0] up_pc,
  input logic            up_valid,
  input logic            up_taken,
  input logic            up_gpred,
  input logic            up_lpred,
  input logic [GH_W-1:0] lk_gidx,
  input logic [LH_W-1:0] lk_lpat,
  input logic            lk_gpred,
  input logic            lk_lpred,
  input logic            lk_taken,
  input logic            lk_sel_global
);

  // R2: the outcome enters the global history at bit 0
  a_r2_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lk_gidx == {$past(lk_gidx[GH_W-2:0]), $past(up_taken)});

  // R9: history is held when no update is presented
  a_r9_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_gidx));

  // R3: the looked-up branch's own history shifts on its update
  a_r3_lhist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && lk_pc == up_pc) |=>
      (lk_pc != $past(lk_pc) ||
       lk_lpat == {$past(lk_lpat[LH_W-2:0]), $past(up_taken)}));

  // R6: agreement of the components leaves the chooser alone
  a_r6_chooser_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_gpred == up_lpred && lk_pc == up_pc) |=>
      (lk_pc != $past(lk_pc) || lk_sel_global == $past(lk_sel_global)));

  // R7: when both components agree the final guess follows them
  a_r7_agree_final: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_gpred == lk_lpred) |-> (lk_taken == lk_gpred));

endmodule

bind tourn_pred tourn_pred_chk #(.PC_W(PC_W), .GH_W(GH_W), .LH_W(LH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_pc(up_pc),
  .up_valid(up_valid), .up_taken(up_taken),
  .up_gpred(up_gpred), .up_lpred(up_lpred),
  .lk_gidx(lk_gidx), .lk_lpat(lk_lpat),
  .lk_gpred(lk_gpred), .lk_lpred(lk_lpred),
  .lk_taken(lk_taken), .lk_sel_global(lk_sel_global)
);

// File: tb/tourn_pred_tb.sv
`timescale 1ns/1ps
module tourn_pred_tb;
  localparam int PC_W = 32;
  localparam int GH_W = 12;
  localparam int LH_W = 10;
  localparam logic [GH_W-1:0] GD  = 12'hABC;
  localparam logic [LH_W-1:0] LD  = 10'h155;
  localparam logic [PC_W-1:0] DPC = 32'h0000_0FFC;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_taken, lk_sel_global, lk_gpred, lk_lpred;
  logic [GH_W-1:0] lk_gidx;
  logic [LH_W-1:0] lk_lpat;
  logic            up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;
  logic [GH_W-1:0] up_gidx = '0;
  logic [LH_W-1:0] up_lpat = '0;
  logic            up_gpred = 1'b0;
  logic            up_lpred = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  tourn_pred u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .lk_sel_global(lk_sel_global),
    .lk_gpred(lk_gpred), .lk_lpred(lk_lpred),
    .lk_gidx(lk_gidx), .lk_lpat(lk_lpat),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_gidx(up_gidx), .up_lpat(up_lpat),
    .up_gpred(up_gpred), .up_lpred(up_lpred)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic t, input logic [GH_W-1:0] gi,
                     input logic [LH_W-1:0] lp, input logic gp, input logic lpr);
    @(negedge clk);
    up_pc = pc; up_taken = t; up_gidx = gi; up_lpat = lp;
    up_gpred = gp; up_lpred = lpr; up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    lk_pc = pc;
    #1;
  endtask

  // Twelve not-taken updates on dummy entries bring the global history to zero.
  task automatic clr_ghist(input logic [PC_W-1:0] pc);
    for (int i = 0; i < GH_W; i++) upd(pc, 1'b0, GD, LD, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    look(32'h0);
    chk("R1 gidx", 32'(lk_gidx), 0);
    chk("R1 lpat", 32'(lk_lpat), 0);
    chk("R1 gpred", 32'(lk_gpred), 0);
    chk("R1 lpred", 32'(lk_lpred), 0);
    chk("R1 sel_global", 32'(lk_sel_global), 0);
    chk("R1 taken", 32'(lk_taken), 0);
  endtask

  task automatic t_ghist;
    upd(DPC, 1'b1, GD, LD, 1'b0, 1'b0);
    upd(DPC, 1'b0, GD, LD, 1'b0, 1'b0);
    upd(DPC, 1'b1, GD, LD, 1'b0, 1'b0);
    upd(DPC, 1'b1, GD, LD, 1'b0, 1'b0);
    look(32'h0);
    chk("R2 ghist 1011", 32'(lk_gidx), 32'hB);
    // R9: inputs toggle with up_valid low
    @(negedge clk);
    up_pc = 32'h40; up_taken = 1'b1; up_gidx = 12'h0; up_lpat = 10'h0;
    up_gpred = 1'b1; up_lpred = 1'b0;
    repeat (3) @(negedge clk);
    look(32'h40);
    chk("R9 ghist held", 32'(lk_gidx), 32'hB);
    chk("R9 lhist held", 32'(lk_lpat), 0);
    chk("R9 chooser held", 32'(lk_sel_global), 0);
    clr_ghist(DPC);
    look(32'h0);
    chk("R2 ghist cleared", 32'(lk_gidx), 0);
  endtask

  task automatic t_lhist;
    upd(32'h40, 1'b1, GD, LD, 1'b0, 1'b0);
    upd(32'h40, 1'b1, GD, LD, 1'b0, 1'b0);
    upd(32'h40, 1'b0, GD, LD, 1'b0, 1'b0);
    look(32'h40);
    chk("R3 lhist of A", 32'(lk_lpat), 32'h6);
    look(32'h44);
    chk("R3 neighbour untouched", 32'(lk_lpat), 0);
    look(32'h1040);
    chk("R3 alias shares entry", 32'(lk_lpat), 32'h6);
  endtask

  task automatic t_gctr;
    upd(DPC, 1'b1, 12'h0, LD, 1'b0, 1'b0); clr_ghist(DPC);
    look(32'h0);   chk("R4 one taken", 32'(lk_gpred), 1);
    upd(DPC, 1'b1, 12'h0, LD, 1'b0, 1'b0); clr_ghist(DPC);
    look(32'h7FC); chk("R4 strong taken, any pc", 32'(lk_gpred), 1);
    upd(DPC, 1'b0, 12'h0, LD, 1'b0, 1'b0); clr_ghist(DPC);
    look(32'h0);   chk("R4 hysteresis", 32'(lk_gpred), 1);
    upd(DPC, 1'b0, 12'h0, LD, 1'b0, 1'b0); clr_ghist(DPC);
    look(32'h0);   chk("R4 second miss flips", 32'(lk_gpred), 0);
  endtask

  task automatic t_lctr;
    upd(DPC, 1'b1, GD, 10'h0, 1'b0, 1'b0);
    look(32'h800); chk("R5 one taken", 32'(lk_lpred), 1);
    for (int i = 0; i < 7; i++) upd(DPC, 1'b1, GD, 10'h0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) upd(DPC, 1'b0, GD, 10'h0, 1'b0, 1'b0);
    look(32'h800); chk("R5 top saturation", 32'(lk_lpred), 1);
    upd(DPC, 1'b0, GD, 10'h0, 1'b0, 1'b0);
    look(32'h800); chk("R5 fourth miss", 32'(lk_lpred), 0);
    for (int i = 0; i < 10; i++) upd(DPC, 1'b0, GD, 10'h0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) upd(DPC, 1'b1, GD, 10'h0, 1'b0, 1'b0);
    look(32'h800); chk("R5 floor saturation", 32'(lk_lpred), 0);
    upd(DPC, 1'b1, GD, 10'h0, 1'b0, 1'b0);
    look(32'h800); chk("R5 climb back", 32'(lk_lpred), 1);
    clr_ghist(DPC);
  endtask

  task automatic t_chooser;
    logic [PC_W-1:0] c = 32'h500;
    upd(c, 1'b1, GD, LD, 1'b1, 1'b0);
    look(c); chk("R6 toward global", 32'(lk_sel_global), 1);
    upd(c, 1'b0, GD, LD, 1'b1, 1'b1);
    upd(c, 1'b1, GD, LD, 1'b1, 1'b1);
    look(c); chk("R6 agreement ignored", 32'(lk_sel_global), 1);
    upd(c, 1'b1, GD, LD, 1'b0, 1'b1);
    look(c); chk("R6 toward local", 32'(lk_sel_global), 0);
    upd(c, 1'b0, GD, LD, 1'b0, 1'b1);
    upd(c, 1'b0, GD, LD, 1'b0, 1'b1);
    upd(c, 1'b1, GD, LD, 1'b0, 1'b1);
    look(c); chk("R6 hysteresis", 32'(lk_sel_global), 1);
    clr_ghist(c);
    look(c);
    chk("R6 lhist cleared", 32'(lk_lpat), 0);
  endtask

  task automatic t_final;
    look(32'h500);
    chk("R7 global chosen gpred", 32'(lk_gpred), 0);
    chk("R7 global chosen lpred", 32'(lk_lpred), 1);
    chk("R7 final follows global", 32'(lk_taken), 0);
    look(32'h900);
    chk("R7 local chosen", 32'(lk_sel_global), 0);
    chk("R7 final follows local", 32'(lk_taken), 1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lk_pc = 32'h500;
    up_pc = 32'h500; up_taken = 1'b1; up_gidx = 12'h0; up_lpat = 10'h0;
    up_gpred = 1'b0; up_lpred = 1'b1; up_valid = 1'b1;
    #1;
    chk("R8 old sel", 32'(lk_sel_global), 1);
    chk("R8 old gidx", 32'(lk_gidx), 0);
    chk("R8 old lpat", 32'(lk_lpat), 0);
    chk("R8 old gpred", 32'(lk_gpred), 0);
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    chk("R8 new sel", 32'(lk_sel_global), 0);
    chk("R8 new gidx", 32'(lk_gidx), 1);
    chk("R8 new lpat", 32'(lk_lpat), 1);
    chk("R8 new lpred", 32'(lk_lpred), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ghist();
    t_lhist();
    t_gctr();
    t_lctr();
    t_chooser();
    t_final();
    t_same_cycle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule